// File: doc/BRIEF.md
# Two-Operand Integer Execute Unit with Condition Flags

This block carries out the two-operand arithmetic and logic group of a 16-bit word machine. The surrounding pipeline has already resolved both operand specifiers and fetched their values. It strobes the instruction word and the source and destination values into the block together. One clock later the block presents the value to write back, a write enable, a byte-write qualifier and the updated negative, zero, overflow and carry flags. The flags live in a register inside the block.

The block decodes the top four bits of the instruction. The word and byte forms of move, compare, bit-test, bit-clear and bit-set are executed here, along with word add and word subtract. One code is reserved and raises a trap pulse. Three codes belong to other instruction classes; the block hands them off with a forward pulse and the secondary selector field.

The machine's status word can be written through the memory map. To model this, the caller raises a qualifier when the destination resolves to the status word. A result written there replaces the flags the instruction computed.

Top module: `dual_op_alu`

## Requirements
- R1: Opcode bits [15:12] select the operation (hex): 1 MOV, 2 CMP, 3 BIT, 4 BIC, 5 BIS, 6 ADD, 9 MOVB, A CMPB, B BITB, C BICB, D BISB, E SUB (word only), F reserved; codes 0, 7 and 8 are forwarded.
- R2: All outputs are registered and appear on the clock edge that samples `in_valid`; `res_valid`, `reserved_trap` and `fwd_pulse` are single-cycle pulses, and synchronous reset clears the flags and all pulses.
- R3: MOV and MOVB clear V, set Z when the moved value is zero, copy N from the sign bit (bit 15 word, bit 7 byte) and keep C.
- R4: MOVB whose destination field [5:0] is below 8 (register direct) writes 16 bits with bit 7 copied into bits [15:8]; any other MOVB destination asserts `res_byte` with the byte zero-extended in `result`.
- R5: CMP/CMPB form source minus destination at operand size, write nothing, set C when source < destination unsigned, and set V when the operand signs differ and the result sign equals the destination sign.
- R6: SUB writes destination minus source, sets C when source > destination unsigned, and sets V when the operand signs differ and the result sign equals the source sign.
- R7: ADD writes the 16-bit sum, sets C on carry out of bit 15, and sets V when both operands share a sign that the result does not.
- R8: BIT, BIC and BIS form dst&src, dst&~src and dst|src; they clear V, set N and Z from the result and keep C; BIT writes nothing.
- R9: Code F pulses `reserved_trap`, writes nothing and leaves the flags unchanged.
- R10: Codes 0, 7 and 8 pulse `fwd_pulse` with `fwd_sel` equal to instruction bits [11:9], write nothing and leave the flags unchanged.
- R11: `flags` is {N,Z,V,C} in bits 3..0; when a written result targets the status word (`dst_is_status`), the flags take `result[3:0]` instead of the computed flags.
- R12: Byte forms use only bits [7:0] of both operands; non-move byte writes assert `res_byte` with the upper result byte zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: instruction and operands valid |
| instr | input | 16 | Instruction word |
| src_val | input | 16 | Fetched source operand |
| dst_val | input | 16 | Fetched destination operand |
| dst_is_status | input | 1 | Destination resolves to the status word |
| res_valid | output | 1 | An executed instruction completed |
| res_we | output | 1 | Result must be written back |
| res_byte | output | 1 | Write back only the low byte |
| result | output | 16 | Result value |
| flags | output | 4 | {N,Z,V,C} |
| reserved_trap | output | 1 | Reserved-instruction trap pulse |
| fwd_pulse | output | 1 | Instruction belongs to another decoder |
| fwd_sel | output | 3 | Secondary selector, bits [11:9] |

## Verification
Two things can land on the same clock edge: the flag update an instruction computes, and a status-word write of that instruction's own result. The bench provokes this with ADD, BIS, MOV and byte operations whose destination is flagged as the status word. It chooses operands so that the computed flags and the written low nibble disagree. The scoreboard then expects the written nibble to win, and it expects the computed flags to win on a neighbouring instruction that writes nothing.

// File: rtl/dual_op_alu_pkg.sv
package dual_op_alu_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_MOV, OP_CMP, OP_BIT, OP_BIC, OP_BIS, OP_ADD, OP_SUB
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_EXEC, CLS_FWD, CLS_RSVD
  } op_class_e;

  // sign bit of a value at the active operand size
  function automatic logic size_sign(input logic [15:0] v, input logic is_byte);
    return is_byte ? v[7] : v[15];
  endfunction

  // overflow when operands agree in sign and the result does not
  function automatic logic add_ovf(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  // overflow for a difference: operand signs differ and result sign equals ref_sign
  function automatic logic diff_ovf(input logic sa, input logic sb, input logic sr,
                                    input logic ref_sign);
    return (sa != sb) && (sr == ref_sign);
  endfunction
endpackage

// File: rtl/alu2_decode.sv
module alu2_decode
  import dual_op_alu_pkg::*;
(
  input  logic [3:0] opc,
  output alu_op_e    op,
  output logic       is_byte,
  output op_class_e  cls
);
  always_comb begin
    op      = OP_NONE;
    is_byte = 1'b0;
    cls     = CLS_EXEC;
    unique case (opc)
      4'h1, 4'h9: op = OP_MOV;
      4'h2, 4'hA: op = OP_CMP;
      4'h3, 4'hB: op = OP_BIT;
      4'h4, 4'hC: op = OP_BIC;
      4'h5, 4'hD: op = OP_BIS;
      4'h6:       op = OP_ADD;
      4'hE:       op = OP_SUB;
      4'hF:       cls = CLS_RSVD;
      default:    cls = CLS_FWD;   // 0, 7, 8
    endcase
    is_byte = opc[3] && (op != OP_NONE) && (op != OP_SUB);
  end
endmodule

// File: rtl/alu2_exec.sv
module alu2_exec
  import dual_op_alu_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e       op,
  input  logic          is_byte,
  input  logic          dst_reg,
  input  logic          c_in,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] dst,
  output logic [DW-1:0] res,
  output logic          we,
  output logic          byte_wr,
  output logic [3:0]    nzvc
);
  localparam int BW = DW / 2;

  logic [DW-1:0] s, d, t;
  logic [DW:0]   wide;
  logic          sa, sb, sr, n, z, v, c;

  always_comb begin
    s = is_byte ? {{BW{1'b0}}, src[BW-1:0]} : src;
    d = is_byte ? {{BW{1'b0}}, dst[BW-1:0]} : dst;
    sa = size_sign(s, is_byte);
    sb = size_sign(d, is_byte);
    wide = '0;
    t  = '0;
    c  = c_in;
    we = 1'b0;
    unique case (op)
      OP_MOV: begin t = s;      we = 1'b1; end
      OP_CMP: begin t = s - d;  c = (s < d); end
      OP_BIT: begin t = d & s;  end
      OP_BIC: begin t = d & ~s; we = 1'b1; end
      OP_BIS: begin t = d | s;  we = 1'b1; end
      OP_ADD: begin
        wide = {1'b0, s} + {1'b0, d};
        t = wide[DW-1:0];
        c = wide[DW];
        we = 1'b1;
      end
      OP_SUB: begin t = d - s;  c = (s > d); we = 1'b1; end
      default: t = '0;
    endcase
    if (is_byte) t = {{BW{1'b0}}, t[BW-1:0]};
    sr = size_sign(t, is_byte);
    n  = sr;
    z  = (t == '0);
    unique case (op)
      OP_CMP:  v = diff_ovf(sa, sb, sr, sb);
      OP_SUB:  v = diff_ovf(sa, sb, sr, sa);
      OP_ADD:  v = add_ovf(sa, sb, sr);
      default: v = 1'b0;
    endcase
    nzvc = {n, z, v, c};
    // byte move into a register widens with the sign; other byte writes stay narrow
    if (op == OP_MOV && is_byte && dst_reg) begin
      res     = {{BW{t[BW-1]}}, t[BW-1:0]};
      byte_wr = 1'b0;
    end else begin
      res     = t;
      byte_wr = is_byte && we;
    end
  end
endmodule

// File: rtl/dual_op_alu.sv
module dual_op_alu
  import dual_op_alu_pkg::*;
#(
  parameter int DW      = 16,
  parameter int SPEC_W  = 6,
  parameter int NUM_REG = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] instr,
  input  logic [DW-1:0] src_val,
  input  logic [DW-1:0] dst_val,
  input  logic          dst_is_status,
  output logic          res_valid,
  output logic          res_we,
  output logic          res_byte,
  output logic [DW-1:0] result,
  output logic [3:0]    flags,
  output logic          reserved_trap,
  output logic          fwd_pulse,
  output logic [2:0]    fwd_sel
);
  localparam int OPC_LSB = DW - 4;
  localparam int SEL_LSB = OPC_LSB - 3;

  alu_op_e       dec_op;
  logic          dec_byte;
  op_class_e     dec_cls;
  logic          dst_reg;
  logic [DW-1:0] ex_res;
  logic          ex_we, ex_byte;
  logic [3:0]    ex_nzvc;
  logic          fire_exec, fire_fwd, fire_rsvd, status_hit;
  logic          unused_src_spec;

  assign unused_src_spec = ^instr[SEL_LSB-1:SPEC_W];
  assign dst_reg = (instr[SPEC_W-1:0] < SPEC_W'(NUM_REG));

  alu2_decode u_dec (
    .opc     (instr[DW-1:OPC_LSB]),
    .op      (dec_op),
    .is_byte (dec_byte),
    .cls     (dec_cls)
  );

  alu2_exec #(.DW(DW)) u_exec (
    .op      (dec_op),
    .is_byte (dec_byte),
    .dst_reg (dst_reg),
    .c_in    (flags[0]),
    .src     (src_val),
    .dst     (dst_val),
    .res     (ex_res),
    .we      (ex_we),
    .byte_wr (ex_byte),
    .nzvc    (ex_nzvc)
  );

  assign fire_exec  = in_valid && (dec_cls == CLS_EXEC);
  assign fire_fwd   = in_valid && (dec_cls == CLS_FWD);
  assign fire_rsvd  = in_valid && (dec_cls == CLS_RSVD);
  assign status_hit = fire_exec && ex_we && dst_is_status;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid     <= 1'b0;
      res_we        <= 1'b0;
      res_byte      <= 1'b0;
      result        <= '0;
      flags         <= '0;
      reserved_trap <= 1'b0;
      fwd_pulse     <= 1'b0;
      fwd_sel       <= '0;
    end else begin
      res_valid     <= fire_exec;
      res_we        <= fire_exec && ex_we;
      res_byte      <= fire_exec && ex_byte;
      reserved_trap <= fire_rsvd;
      fwd_pulse     <= fire_fwd;
      if (fire_exec) result <= ex_res;
      if (fire_fwd)  fwd_sel <= instr[OPC_LSB-1:SEL_LSB];
      // computed flags first; a status-word write of the result then overrides them
      if (fire_exec) flags <= status_hit ? ex_res[3:0] : ex_nzvc;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({res_valid, reserved_trap, fwd_pulse}));  // R2
  AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    reserved_trap |-> !res_we);  // R9
  AST_TRAP_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    fire_rsvd |=> $stable(flags));  // R9
  AST_FWD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    fire_fwd |=> ($stable(flags) && !res_we));  // R10
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (dec_op == OP_CMP || dec_op == OP_BIT)) |=> (res_valid && !res_we));  // R5
  AST_MOV_CLEARS_V: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_op == OP_MOV && !dst_is_status) |=> !flags[1]);  // R3
  AST_IDLE_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(flags) && !res_valid));  // R2
endmodule

// File: tb/dual_op_alu_tb.sv
module dual_op_alu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] instr = '0, src_val = '0, dst_val = '0;
  logic        dst_is_status = 1'b0;
  logic        res_valid, res_we, res_byte, reserved_trap, fwd_pulse;
  logic [15:0] result;
  logic [3:0]  flags;
  logic [2:0]  fwd_sel;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    bit         valid, we, bytew, trap, fwd;
    logic [15:0] res;
    logic [3:0] fl;
    logic [2:0] sel;
  } exp_t;
  exp_t exp_q[$];
  logic [3:0] m_flags = 4'h0;

  always #10 clk = ~clk;  // 50 MHz

  dual_op_alu u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_val(src_val), .dst_val(dst_val), .dst_is_status(dst_is_status),
    .res_valid(res_valid), .res_we(res_we), .res_byte(res_byte),
    .result(result), .flags(flags), .reserved_trap(reserved_trap),
    .fwd_pulse(fwd_pulse), .fwd_sel(fwd_sel)
  );

  // reference model built from the requirement text, in integer arithmetic
  task automatic send(input string tag, input logic [3:0] opc, input logic [5:0] dspec,
                      input logic [15:0] s, input logic [15:0] d, input bit st);
    exp_t e;
    int code = opc;
    bit bytef = (code >= 9 && code <= 13);
    int msk = bytef ? 255 : 65535;
    int sg  = bytef ? 128 : 32768;
    int a = s & msk, b = d & msk, r = 0;
    bit n, z, v = 0, c = m_flags[0], wr = 0;
    e.tag = tag; e.valid = 0; e.we = 0; e.bytew = 0; e.trap = 0; e.fwd = 0;
    e.res = 'x; e.fl = m_flags; e.sel = 3'(code == 0 ? 1 : 0);
    e.sel = 3'b101;
    if (code == 15) e.trap = 1;
    else if (code == 0 || code == 7 || code == 8) e.fwd = 1;
    else begin
      e.valid = 1;
      case (code)
        1, 9:   begin r = a; wr = 1; end
        2, 10:  begin r = (a - b) & msk; c = a < b;
                      v = ((a ^ b) & sg) != 0 && ((r ^ b) & sg) == 0; end
        3, 11:  r = a & b;
        4, 12:  begin r = b & ~a & msk; wr = 1; end
        5, 13:  begin r = a | b; wr = 1; end
        6:      begin r = a + b; c = r > 65535; r = r & 65535; wr = 1;
                      v = ((a ^ b) & sg) == 0 && ((r ^ a) & sg) != 0; end
        default: begin r = (b - a) & 65535; c = a > b; wr = 1;
                      v = ((a ^ b) & sg) != 0 && ((r ^ a) & sg) == 0; end
      endcase
      n = (r & sg) != 0;
      z = (r == 0);
      e.bytew = bytef && wr;
      if (code == 9 && dspec < 8) begin
        e.bytew = 0;
        if ((r & 128) != 0) r = r | 16'hFF00;
      end
      m_flags = {n, z, v, c};
      if (wr && st) m_flags = 4'(r & 15);
      e.we = wr; e.res = 16'(r); e.fl = m_flags;
    end
    exp_q.push_back(e);
    @(negedge clk);
    in_valid = 1'b1;
    instr = {opc, 3'b101, 3'b011, dspec};
    src_val = s; dst_val = d; dst_is_status = st;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: pop the scoreboard each time the design samples a strobe
  initial begin
    forever begin
      @(posedge clk);
      if (!rst && in_valid) begin
        exp_t e;
        bit bad;
        #5;
        e = exp_q.pop_front();
        bad = (res_valid !== e.valid) || (res_we !== e.we) || (reserved_trap !== e.trap) ||
              (fwd_pulse !== e.fwd) || (flags !== e.fl) ||
              (e.we && ((result !== e.res) || (res_byte !== e.bytew))) ||
              (e.fwd && fwd_sel !== e.sel);
        checks++;
        if (bad) begin
          failures++;
          $display("FAIL %s: got v=%0b we=%0b byte=%0b res=%h fl=%b trap=%0b fwd=%0b sel=%0d exp v=%0b we=%0b byte=%0b res=%h fl=%b trap=%0b fwd=%0b sel=%0d",
                   e.tag, res_valid, res_we, res_byte, result, flags, reserved_trap, fwd_pulse, fwd_sel,
                   e.valid, e.we, e.bytew, e.res, e.fl, e.trap, e.fwd, e.sel);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog: got hang expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;  // R2 reset state
    if (flags !== 4'h0 || res_valid || reserved_trap || fwd_pulse || res_we) begin
      failures++;
      $display("FAIL R2 reset: got fl=%b v=%0b trap=%0b fwd=%0b expected fl=0000 pulses 0",
               flags, res_valid, reserved_trap, fwd_pulse);
    end
    send("R3 mov neg",        4'h1, 6'o01, 16'h8000, 16'h1234, 0);
    send("R3 mov zero",       4'h1, 6'o01, 16'h0000, 16'h1234, 0);
    send("R7 add carry",      4'h6, 6'o02, 16'hFFFF, 16'h0001, 0);
    send("R3 mov keeps C",    4'h1, 6'o02, 16'h0042, 16'h0000, 0);
    send("R7 add ovf",        4'h6, 6'o02, 16'h7FFF, 16'h0001, 0);
    idle();
    send("R4 movb sext reg",  4'h9, 6'o03, 16'h1280, 16'h0000, 0);
    send("R4 movb mem byte",  4'h9, 6'o12, 16'h12F0, 16'h0000, 0);
    send("R4 movb pos reg",   4'h9, 6'o00, 16'hFF7F, 16'h0000, 0);
    send("R5 cmp borrow",     4'h2, 6'o01, 16'h0003, 16'h0005, 0);
    send("R5 cmp ovf",        4'h2, 6'o01, 16'h8000, 16'h0001, 0);
    send("R5 cmp equal",      4'h2, 6'o01, 16'h1234, 16'h1234, 0);
    send("R12 cmpb low",      4'hA, 6'o01, 16'hFF80, 16'h0001, 0);
    send("R6 sub plain",      4'hE, 6'o04, 16'h0003, 16'h0005, 0);
    send("R6 sub borrow",     4'hE, 6'o04, 16'h0002, 16'h0001, 0);
    send("R6 sub ovf",        4'hE, 6'o04, 16'h0001, 16'h8000, 0);
    send("R8 bit",            4'h3, 6'o05, 16'h00F0, 16'h8F0F, 0);
    send("R8 bic",            4'h4, 6'o05, 16'h00FF, 16'h80F0, 0);
    send("R8 bis",            4'h5, 6'o15, 16'h0101, 16'h1010, 0);
    send("R12 bicb",          4'hC, 6'o05, 16'h0F0F, 16'hFFFF, 0);
    send("R12 bisb neg",      4'hD, 6'o05, 16'h0080, 16'hAA00, 0);
    send("R8 bitb zero",      4'hB, 6'o05, 16'hFF00, 16'h00FF, 0);
    send("R9 reserved",       4'hF, 6'o00, 16'hFFFF, 16'hFFFF, 0);
    send("R10 fwd 0",         4'h0, 6'o00, 16'h0000, 16'h0000, 0);
    send("R10 fwd 7",         4'h7, 6'o00, 16'h0000, 16'h0000, 0);
    send("R10 fwd 8",         4'h8, 6'o00, 16'h0000, 16'h0000, 1);
    send("R11 add to status", 4'h6, 6'o17, 16'hFFFF, 16'h0006, 1);
    send("R11 bis to status", 4'h5, 6'o17, 16'h000A, 16'h0000, 1);
    send("R11 cmp no override", 4'h2, 6'o17, 16'h0001, 16'h0001, 1);
    send("R11 movb status",   4'h9, 6'o17, 16'h00F3, 16'h0000, 1);
    send("R1 trap after",     4'hF, 6'o00, 16'h0000, 16'h0000, 0);
    idle();
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule